// File: doc/BRIEF.md
# Programming-Mode Row Write Controller

This block is the memory-side engine of a small controller's serial programming mode. An upstream deserializer hands it one decoded command at a time: load a word, read a word, step the address, start a write, finish a write, or erase. The block keeps a forward-only 12-bit address over a 4096-word programming space. The lower half of that space is user code. The upper half holds four identification words at its base and a single configuration word at its very top.

Loaded words collect in a four-entry row latch, indexed by the two low address bits. A write command programs every latch entry loaded since the last finish. In user space it writes a whole aligned row. In configuration space it writes only the addressed word. Programming can only clear bits, so the attached array ANDs each new word into the stored one.

On the read path the block forces the two spare top bits to one. It blanks protected user words and the configuration word once that word has been closed off. Commands enter through a valid/ready channel. The read result leaves through a valid/ready channel that holds its word until it is taken. The array itself sits outside the block, behind a plain request port with one cycle of read latency.

Top module: `pgm_row_ctrl`

## Requirements
- R1: After reset or a `mode_enter` pulse, the address is 0xFFF, the configuration word is open, the latch holds all ones with no entry loaded, and `cmd_ready` is high.
- R2: The increment command (code 2) adds one to the address, stepping 0x7FF to 0x800 and 0xFFF to 0x000. No command lowers the address.
- R3: The configuration word at 0xFFF can be read and written only before the first increment after entry. After that first increment it reads as data 0 and is never written.
- R4: In user space (address bit 11 = 0), the begin command (code 3) writes each latch entry i loaded since the last end command to address {addr[11:2], i}, in ascending i. Unloaded entries are not written. The array stores the AND of the old word and the new word.
- R5: In configuration space, begin writes only the addressed word, and only when that word is an ID word (0x800–0x803) or the open configuration word. Every other configuration address gets no write and reads as data 0.
- R6: The end command (code 4) returns all latch entries to all ones and marks them unloaded, so a following begin with no load writes nothing.
- R7: Between begin and end, every command other than end is accepted and has no effect.
- R8: The load command (code 0) keeps the low 12 bits of the 14-bit word in the entry at addr[1:0]. A read (code 1) returns bits 13:12 as ones.
- R9: When `prot_n` is 0, user addresses above 0x03F read as data 0. Addresses 0x000–0x03F, the ID words and the open configuration word read normally.
- R10: The erase command (code 5) pulses `mem_erase` for one cycle. It also raises `mem_erase_ids` when the address is at or above 0x800 and the configuration word is closed.
- R11: `cmd_ready` is low while a write sweep or a read is in progress. A pending read word stays valid and stable until `rd_ready` takes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_enter | input | 1 | Programming-mode entry pulse |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted this cycle when valid |
| cmd_op | input | 3 | Command code: 0 load, 1 read, 2 increment, 3 begin, 4 end, 5 erase |
| cmd_word | input | 14 | Load word |
| rd_valid | output | 1 | Read word available |
| rd_ready | input | 1 | Consumer takes the read word |
| rd_word | output | 14 | Masked read word |
| prot_n | input | 1 | Code-protect bit of the configuration word, active low |
| mem_rd_en | output | 1 | Array read request |
| mem_wr_en | output | 1 | Array program request (AND-write) |
| mem_addr | output | 12 | Array address |
| mem_wr_data | output | 12 | Array program data |
| mem_rdata | input | 12 | Array read data, one cycle after the request |
| mem_erase | output | 1 | Erase user space and configuration word |
| mem_erase_ids | output | 1 | Also erase the ID words |

## Verification
The embedded assertions check on every cycle the following properties:
- the address step and wrap;
- the entry state;
- the legality of every write address;
- that the configuration word is written only while open;
- the forced top bits;
- read hold under back-pressure;
- the busy window.

Only the bench scenarios can show that row writes touch exactly the loaded entries and that AND-programming combines old and new words. The same holds for protection blanking across the full address sweep, for commands ignored during programming, and for whether an erase reaches the ID words.

// File: rtl/pgm_pkg.sv
package pgm_pkg;
  typedef enum logic [2:0] {
    OP_LOAD  = 3'd0,
    OP_READ  = 3'd1,
    OP_INCR  = 3'd2,
    OP_BEGIN = 3'd3,
    OP_END   = 3'd4,
    OP_ERASE = 3'd5
  } pgm_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WRITE,
    ST_HOLD,
    ST_RDREQ,
    ST_RDCAP,
    ST_RDOUT
  } pgm_st_e;
endpackage

// File: rtl/pgm_addr_ctr.sv
module pgm_addr_ctr #(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enter,
  input  logic              inc,
  output logic [ADDR_W-1:0] pc,
  output logic              cfg_open
);
  always_ff @(posedge clk) begin
    if (!rst_n || enter) begin
      pc       <= '1;
      cfg_open <= 1'b1;
    end else if (inc) begin
      pc       <= pc + ADDR_W'(1);
      cfg_open <= 1'b0;
    end
  end

  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !enter) |=> (pc == $past(pc) + ADDR_W'(1)) && !cfg_open); // R2
  AST_PC_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    enter |=> (&pc) && cfg_open); // R1
endmodule

// File: rtl/pgm_row_latch.sv
module pgm_row_latch #(
  parameter int unsigned WORD_W    = 12,
  parameter int unsigned ROW_WORDS = 4,
  localparam int unsigned IDX_W    = $clog2(ROW_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              load,
  input  logic [IDX_W-1:0]  load_idx,
  input  logic [WORD_W-1:0] load_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_loaded
);
  logic [WORD_W-1:0]    ent [ROW_WORDS];
  logic [ROW_WORDS-1:0] loaded;

  for (genvar i = 0; i < ROW_WORDS; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
        ent[i]    <= '1;
        loaded[i] <= 1'b0;
      end else if (load && load_idx == IDX_W'(i)) begin
        ent[i]    <= load_data;
        loaded[i] <= 1'b1;
      end
    end
  end

  assign rd_data   = ent[rd_idx];
  assign rd_loaded = loaded[rd_idx];
endmodule

// File: rtl/pgm_read_mask.sv
module pgm_read_mask #(
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned WORD_W     = 12,
  parameter int unsigned BUS_W      = 14,
  parameter int unsigned PROT_LIMIT = 'h3F,
  parameter int unsigned ID_COUNT   = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              cfg_open,
  input  logic              prot_n,
  input  logic [WORD_W-1:0] raw,
  output logic [BUS_W-1:0]  word
);
  logic              in_user, in_id, in_cfg, blanked;
  logic [WORD_W-1:0] data;

  always_comb begin
    in_user = !addr[ADDR_W-1];
    in_id   = addr[ADDR_W-1] && (addr[ADDR_W-2:0] < (ADDR_W-1)'(ID_COUNT));
    in_cfg  = &addr;
    blanked = !prot_n && (addr > ADDR_W'(PROT_LIMIT));
    if (in_user)                data = blanked ? '0 : raw;
    else if (in_id)             data = raw;
    else if (in_cfg && cfg_open) data = raw;
    else                        data = '0;
    word = {{(BUS_W-WORD_W){1'b1}}, data};
  end
endmodule

// File: rtl/pgm_row_ctrl.sv
module pgm_row_ctrl
  import pgm_pkg::*;
#(
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned WORD_W     = 12,
  parameter int unsigned BUS_W      = 14,
  parameter int unsigned ROW_WORDS  = 4,
  parameter int unsigned ID_COUNT   = 4,
  parameter int unsigned PROT_LIMIT = 'h3F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_enter,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_op,
  input  logic [BUS_W-1:0]  cmd_word,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [BUS_W-1:0]  rd_word,
  input  logic              prot_n,
  output logic              mem_rd_en,
  output logic              mem_wr_en,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wr_data,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              mem_erase,
  output logic              mem_erase_ids
);
  localparam int unsigned IDX_W = $clog2(ROW_WORDS);

  pgm_st_e           st;
  logic [IDX_W-1:0]  widx;
  logic [ADDR_W-1:0] pc;
  logic              cfg_open;
  logic              fire, act, do_inc, do_load, do_clear;
  logic [WORD_W-1:0] lat_data;
  logic              lat_loaded;
  logic              pc_user, pc_id, pc_cfg, single_ok, slot_ok;
  logic [BUS_W-1:0]  masked;
  logic              unused_hi;

  assign unused_hi = ^cmd_word[BUS_W-1:WORD_W];

  assign cmd_ready = (st == ST_IDLE) || (st == ST_HOLD);
  assign fire      = cmd_valid && cmd_ready;
  assign act       = fire && (st == ST_IDLE);
  assign do_inc    = act && (cmd_op == OP_INCR);
  assign do_load   = act && (cmd_op == OP_LOAD);
  assign do_clear  = mode_enter || (fire && cmd_op == OP_END);

  pgm_addr_ctr #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .enter(mode_enter), .inc(do_inc),
    .pc(pc), .cfg_open(cfg_open)
  );

  pgm_row_latch #(.WORD_W(WORD_W), .ROW_WORDS(ROW_WORDS)) u_latch (
    .clk(clk), .rst_n(rst_n), .clear(do_clear), .load(do_load),
    .load_idx(pc[IDX_W-1:0]), .load_data(cmd_word[WORD_W-1:0]),
    .rd_idx(widx), .rd_data(lat_data), .rd_loaded(lat_loaded)
  );

  pgm_read_mask #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .BUS_W(BUS_W),
    .PROT_LIMIT(PROT_LIMIT), .ID_COUNT(ID_COUNT)
  ) u_mask (
    .addr(pc), .cfg_open(cfg_open), .prot_n(prot_n),
    .raw(mem_rdata), .word(masked)
  );

  // Write-target classification for the sweep over latch entries.
  always_comb begin
    pc_user   = !pc[ADDR_W-1];
    pc_id     = pc[ADDR_W-1] && (pc[ADDR_W-2:0] < (ADDR_W-1)'(ID_COUNT));
    pc_cfg    = &pc;
    single_ok = pc_id || (pc_cfg && cfg_open);
    slot_ok   = lat_loaded &&
                (pc_user || (single_ok && widx == pc[IDX_W-1:0]));
  end

  assign mem_wr_en   = (st == ST_WRITE) && slot_ok;
  assign mem_rd_en   = (st == ST_RDREQ);
  assign mem_addr    = (st == ST_WRITE) ? {pc[ADDR_W-1:IDX_W], widx} : pc;
  assign mem_wr_data = lat_data;
  assign rd_valid    = (st == ST_RDOUT);

  always_ff @(posedge clk) begin
    if (!rst_n || mode_enter) begin
      st            <= ST_IDLE;
      widx          <= '0;
      mem_erase     <= 1'b0;
      mem_erase_ids <= 1'b0;
      if (!rst_n) rd_word <= '0;
    end else begin
      mem_erase     <= 1'b0;
      mem_erase_ids <= 1'b0;
      case (st)
        ST_IDLE: if (act) begin
          case (cmd_op)
            OP_READ:  st <= ST_RDREQ;
            OP_BEGIN: begin st <= ST_WRITE; widx <= '0; end
            OP_ERASE: begin
              mem_erase     <= 1'b1;
              mem_erase_ids <= pc[ADDR_W-1] && !cfg_open;
            end
            default: ;
          endcase
        end
        ST_WRITE: begin
          widx <= widx + IDX_W'(1);
          if (widx == IDX_W'(ROW_WORDS-1)) st <= ST_HOLD;
        end
        ST_HOLD:  if (fire && cmd_op == OP_END) st <= ST_IDLE;
        ST_RDREQ: st <= ST_RDCAP;
        ST_RDCAP: begin rd_word <= masked; st <= ST_RDOUT; end
        ST_RDOUT: if (rd_ready) st <= ST_IDLE;
        default:  st <= ST_IDLE;
      endcase
    end
  end

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready && !mode_enter) |=> rd_valid && $stable(rd_word)); // R11
  AST_BUSY_NO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_en || mem_rd_en) |-> !cmd_ready); // R11
  AST_WR_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> (!mem_addr[ADDR_W-1] || (&mem_addr) ||
                   mem_addr[ADDR_W-2:0] < (ADDR_W-1)'(ID_COUNT))); // R5
  AST_CFG_WR_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_en && (&mem_addr)) |-> cfg_open); // R3
  AST_TOP_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (&rd_word[BUS_W-1:WORD_W])); // R8
endmodule

// File: tb/pgm_row_ctrl_bench.sv
module pgm_row_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_enter = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [2:0]  cmd_op = 3'd0;
  logic [13:0] cmd_word = 14'd0;
  logic        rd_valid;
  logic        rd_ready = 1'b0;
  logic [13:0] rd_word;
  logic        prot_n;
  logic        mem_rd_en, mem_wr_en, mem_erase, mem_erase_ids;
  logic [11:0] mem_addr, mem_wr_data;
  logic [11:0] mem_rdata = 12'd0;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // Behavioural array model
  logic [11:0] arr [4096];
  logic [11:0] last_rd_addr = 12'd0;
  logic [11:0] last_wr_addr = 12'd0;
  logic [11:0] last_wr_data = 12'd0;
  int          wr_count = 0;
  logic        last_ids = 1'b0;

  always #5 clk = ~clk;

  assign prot_n = arr[12'hFFF][3];

  initial for (int i = 0; i < 4096; i++) arr[i] = 12'h5A5;

  always @(posedge clk) begin
    if (mem_erase) begin
      for (int i = 0; i < 2048; i++) arr[i] <= 12'hFFF;
      arr[12'hFFF] <= 12'hFFF;
      if (mem_erase_ids) for (int i = 12'h800; i < 12'h804; i++) arr[i] <= 12'hFFF;
      last_ids <= mem_erase_ids;
    end
    if (mem_wr_en) begin
      arr[mem_addr] <= arr[mem_addr] & mem_wr_data;
      last_wr_addr  <= mem_addr;
      last_wr_data  <= mem_wr_data;
      wr_count      <= wr_count + 1;
    end
    if (mem_rd_en) begin
      mem_rdata    <= arr[mem_addr];
      last_rd_addr <= mem_addr;
    end
  end

  pgm_row_ctrl u_pgm_row_ctrl (
    .clk(clk), .rst_n(rst_n), .mode_enter(mode_enter),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_word(cmd_word), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_word(rd_word), .prot_n(prot_n), .mem_rd_en(mem_rd_en),
    .mem_wr_en(mem_wr_en), .mem_addr(mem_addr), .mem_wr_data(mem_wr_data),
    .mem_rdata(mem_rdata), .mem_erase(mem_erase), .mem_erase_ids(mem_erase_ids)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [2:0] op, input logic [13:0] w);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_word = w;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic enter();
    @(negedge clk); mode_enter = 1'b1;
    @(negedge clk); mode_enter = 1'b0;
  endtask

  task automatic incr(input int n);
    for (int i = 0; i < n; i++) send(3'd2, 14'd0);
  endtask

  task automatic burn();
    send(3'd3, 14'd0);
    send(3'd4, 14'd0);
  endtask

  task automatic rd(output logic [13:0] w, output logic [11:0] a);
    send(3'd1, 14'd0);
    chk(cmd_ready == 1'b0 || rd_valid, "R11 busy during read", {31'd0, cmd_ready}, 32'd0);
    while (!rd_valid) @(negedge clk);
    w = rd_word; a = last_rd_addr;
    @(negedge clk);
    chk(rd_valid && rd_word == w, "R11 hold under back-pressure", {18'd0, rd_word}, {18'd0, w});
    rd_ready = 1'b1;
    @(negedge clk);
    rd_ready = 1'b0;
  endtask

  function automatic logic [13:0] exp_rd(input logic [11:0] a, input bit open);
    logic [11:0] d;
    if (!a[11])                  d = (arr[12'hFFF][3] == 1'b0 && a > 12'h03F) ? 12'h000 : arr[a];
    else if (a < 12'h804)        d = arr[a];
    else if (a == 12'hFFF && open) d = arr[a];
    else                         d = 12'h000;
    return {2'b11, d};
  endfunction

  initial begin
    logic [13:0] w;
    logic [11:0] a;
    int wc;
    repeat (4) @(negedge clk);
    chk(cmd_ready && !rd_valid && !mem_erase, "R1 reset state", {30'd0, cmd_ready, rd_valid}, 32'd2);
    rst_n = 1'b1;
    enter();
    // R10: erase with config open spares the ID words
    send(3'd5, 14'd0);
    repeat (2) @(negedge clk);
    chk(last_ids == 1'b0, "R10 ids kept at entry erase", {31'd0, last_ids}, 32'd0);
    rd(w, a);
    chk(a == 12'hFFF, "R1 entry address", {20'd0, a}, 32'hFFF);
    chk(w == 14'h3FFF, "R10 config erased", {18'd0, w}, 32'h3FFF);
    // R3/R8: write open config word, protect on
    send(3'd0, 14'h2FF7); burn();
    rd(w, a);
    chk(w == 14'h3FF7, "R3 R8 config write and top ones", {18'd0, w}, 32'h3FF7);
    incr(1);
    rd(w, a);
    chk(a == 12'h000 && w == 14'h3FFF, "R2 wrap FFF to 000", {18'd0, w}, 32'h3FFF);
    // R4: full row at 0
    send(3'd0, 14'h0A10); incr(1); send(3'd0, 14'h0A11); incr(1);
    send(3'd0, 14'h0A12); incr(1); send(3'd0, 14'h0A13);
    wc = wr_count; burn();
    chk(wr_count - wc == 4, "R4 full row writes", wr_count - wc, 32'd4);
    // R4: sparse row at 4
    incr(1); send(3'd0, 14'h00B4); incr(2); send(3'd0, 14'h00B6); incr(1);
    wc = wr_count; burn();
    chk(wr_count - wc == 2, "R4 only loaded entries", wr_count - wc, 32'd2);
    incr(1); send(3'd0, 14'h00F0); burn();
    // R4: AND programming at 8
    enter(); incr(9);
    send(3'd0, 14'h0F3F); burn();
    enter(); incr(1);
    for (int i = 0; i < 9; i++) begin
      logic [11:0] e;
      case (i)
        0: e = 12'hA10; 1: e = 12'hA11; 2: e = 12'hA12; 3: e = 12'hA13;
        4: e = 12'h0B4; 6: e = 12'h0B6; 8: e = 12'h0F0 & 12'hF3F;
        default: e = 12'hFFF;
      endcase
      rd(w, a);
      chk(w == {2'b11, e} && a == 12'(i), "R4 row contents", {18'd0, w}, {18'd0, 2'b11, e});
      incr(1);
    end
    // R2 R3 R9: exhaustive address sweep with protection on
    enter();
    rd(w, a);
    chk(w == exp_rd(12'hFFF, 1'b1), "R3 open config read", {18'd0, w}, {18'd0, exp_rd(12'hFFF, 1'b1)});
    incr(1);
    for (int i = 0; i < 4096; i++) begin
      rd(w, a);
      chk(a == 12'(i) && w == exp_rd(12'(i), 1'b0), "R2 R3 R9 sweep",
          {6'd0, a, w}, {6'd0, 12'(i), exp_rd(12'(i), 1'b0)});
      incr(1);
    end
    // R5: single-word ID write
    enter(); incr(12'h801);
    send(3'd0, 14'h0111); incr(1); send(3'd0, 14'h000C);
    wc = wr_count; burn();
    chk(wr_count - wc == 1 && last_wr_addr == 12'h801 && last_wr_data == 12'h00C,
        "R5 single ID word", {20'd0, last_wr_addr}, 32'h801);
    incr(3);
    send(3'd0, 14'h0000);
    wc = wr_count; burn();
    chk(wr_count == wc, "R5 reserved no write", wr_count - wc, 32'd0);
    rd(w, a);
    chk(a == 12'h804 && w == 14'h3000, "R5 reserved reads zero", {18'd0, w}, 32'h3000);
    // R7: commands ignored while programming
    wc = wr_count;
    send(3'd3, 14'd0); send(3'd2, 14'd0); send(3'd0, 14'h0000); send(3'd4, 14'd0);
    rd(w, a);
    chk(a == 12'h804, "R7 increment ignored in programming", {20'd0, a}, 32'h804);
    chk(wr_count == wc, "R6 R7 no write without load", wr_count - wc, 32'd0);
    burn();
    chk(wr_count == wc, "R6 latch cleared by end", wr_count - wc, 32'd0);
    // R10: erase after advancing into config space
    send(3'd5, 14'd0);
    repeat (2) @(negedge clk);
    chk(last_ids == 1'b1, "R10 ids erased", {31'd0, last_ids}, 32'd1);
    enter();
    rd(w, a);
    chk(w == 14'h3FFF, "R10 config erased again", {18'd0, w}, 32'h3FFF);
    incr(12'h41);
    send(3'd0, 14'h1123); burn();
    rd(w, a);
    chk(a == 12'h040 && w == 14'h3123, "R9 R8 unprotected high read", {18'd0, w}, 32'h3123);
    enter();
    send(3'd0, 14'h0FF7); burn();
    incr(12'h41);
    rd(w, a);
    chk(w == 14'h3000, "R9 protected read blanked", {18'd0, w}, 32'h3000);
    incr(12'h7C0);
    rd(w, a);
    chk(a == 12'h800 && w == 14'h3FFF, "R10 ID word erased", {18'd0, w}, 32'h3FFF);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule